// File: doc/BRIEF.md
# Serial Microcontroller Register Port

This block is the slave end of a four-wire serial link through which a host microcontroller configures a tape-read equalizer. The host raises an enable strobe to open a frame, presents a two-bit command that the block latches at that moment, and then moves one byte, least significant bit first, on the rising edges of a slow bit clock. Depending on the command, the byte sets the operating mode, selects a channel/tap address, overwrites one equalizer coefficient, or is returned to the host from a read-back register.

All serial inputs are oversampled on a fast system clock through two-flop synchronizers, and edges are found from the synchronized copies. The block stores a mode register, an address register and a 9 x 12 array of signed 8-bit coefficients. A separate lookup port lets the equalizer datapath read any coefficient combinationally. The speed-status byte is produced elsewhere and enters on an input port. The read-back register returns either that status byte or the addressed coefficient, depending on the exchange-type field of the mode register.

Top module: `serRegPort`

## Requirements
- R1: After reset, the operating mode is 11 (off), the exchange type is 01 (read coefficient), the channel and tap address is 0/0, every coefficient is zero, and the data output enable is low.
- R2: The data output enable is high only inside a frame whose latched command is 01 (read). It stays low during all other frames and outside frames.
- R3: A frame takes its first 8 data bits, LSB first, on rising bit-clock edges. Any bits after the eighth are ignored. A frame that ends with fewer than 8 bits changes no register.
- R4: Command 11 loads the mode byte. Bits 1:0 set the operating mode (00 normal, 01 test, 10 search, 11 off). Bits 3:2 set the exchange type. Bits 7:4 are ignored.
- R5: Command 10 loads the address byte. Bits 7:4 set the channel (0 to 7 are data channels, 8 is the auxiliary channel). Bits 3:0 set the tap (0 to 11).
- R6: Command 00 overwrites the coefficient at the current channel/tap address. The new value appears on the lookup port once the frame's eighth bit has been taken. Before that, the lookup port shows the old value.
- R7: When the current address has a channel above 8 or a tap above 11, a coefficient write changes no cell. A read of such an address returns 0. The lookup port also returns 0 for an out-of-range address.
- R8: A read frame with exchange type 11 returns the status input byte, LSB first, without change. In that byte, bit 7 is the invalid flag, bits 6:2 are the speed count and bits 1:0 are the range.
- R9: A read frame with any other exchange type returns the coefficient at the current address, LSB first. Bit 0 is valid from the start of the frame, and each later bit is valid before the next rising bit-clock edge.
- R10: The command is latched when the enable rises. A change on the command inputs during the frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| serEn | input | 1 | Frame enable strobe from the host |
| serCmd | input | 2 | Command code, latched at enable rise |
| serClk | input | 1 | Serial bit clock from the host |
| serDataIn | input | 1 | Serial data from the host |
| serDataOut | output | 1 | Serial data to the host |
| serDataOe | output | 1 | Drive enable for the shared data line |
| statusIn | input | 8 | Speed status byte from the measurement logic |
| lkChan | input | 4 | Equalizer lookup channel |
| lkTap | input | 4 | Equalizer lookup tap |
| lkCoef | output | 8 | Coefficient at the lookup address |
| opMode | output | 2 | Current operating mode |
| xferType | output | 2 | Current exchange type |
| curChan | output | 4 | Current channel address |
| curTap | output | 4 | Current tap address |

## Verification
A coefficient commit can land in the same system cycle in which the equalizer reads that same cell through the lookup port. To provoke this, the bench points the lookup port at the addressed cell during a write frame. From the eighth rising bit-clock edge onward, it samples the lookup output on every clock. Each sample must equal the old value until the new value appears, and the new value must then stay. Outside frames, a behavioural model is compared on every clock against all register outputs and the output enable.

// File: rtl/serRegPkg.sv
package serRegPkg;
  localparam logic [1:0] CMD_COEF = 2'b00;
  localparam logic [1:0] CMD_READ = 2'b01;
  localparam logic [1:0] CMD_ADDR = 2'b10;
  localparam logic [1:0] CMD_MODE = 2'b11;

  localparam logic [1:0] XT_READ_STATUS = 2'b11;
  localparam logic [1:0] XT_RESET       = 2'b01;
  localparam logic [1:0] MODE_OFF       = 2'b11;

  typedef struct packed {
    logic loadRead;
    logic shiftIn;
    logic shiftOut;
    logic commitMode;
    logic commitAddr;
    logic commitCoef;
    logic driveEn;
  } ctrlStrobe_t;
endpackage

// File: rtl/serSync.sv
module serSync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[s] <= '0;
          else       stage[s] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[s] <= '0;
          else       stage[s] <= stage[s-1];
        end
      end
    end
  endgenerate

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/serCtrl.sv
module serCtrl
  import serRegPkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        enS,
  input  logic        clkS,
  input  logic [1:0]  cmdS,
  output ctrlStrobe_t strobe,
  output logic        frameOn,
  output logic [1:0]  cmdQ
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);

  logic             enPrev, clkPrev;
  logic             enRise, enFall, clkRise;
  logic [CNT_W-1:0] bitCnt;
  logic             doneQ, driveQ;
  logic             takeBit;

  assign enRise  = enS & ~enPrev;
  assign enFall  = ~enS & enPrev;
  assign clkRise = clkS & ~clkPrev;
  assign takeBit = clkRise & frameOn & (bitCnt < FULL_CNT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enPrev  <= 1'b0;
      clkPrev <= 1'b0;
      frameOn <= 1'b0;
      cmdQ    <= CMD_COEF;
      bitCnt  <= '0;
      doneQ   <= 1'b0;
      driveQ  <= 1'b0;
    end else begin
      enPrev  <= enS;
      clkPrev <= clkS;
      doneQ   <= takeBit && (bitCnt == LAST_BIT) && (cmdQ != CMD_READ);
      if (enRise) begin
        frameOn <= 1'b1;
        cmdQ    <= cmdS;
        bitCnt  <= '0;
        driveQ  <= (cmdS == CMD_READ);
      end else if (enFall) begin
        frameOn <= 1'b0;
        driveQ  <= 1'b0;
      end else if (takeBit) begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strobe            = '0;
    strobe.loadRead   = enRise && (cmdS == CMD_READ);
    strobe.shiftIn    = takeBit && (cmdQ != CMD_READ);
    strobe.shiftOut   = takeBit && (cmdQ == CMD_READ);
    strobe.commitMode = doneQ && (cmdQ == CMD_MODE);
    strobe.commitAddr = doneQ && (cmdQ == CMD_ADDR);
    strobe.commitCoef = doneQ && (cmdQ == CMD_COEF);
    strobe.driveEn    = driveQ;
  end
endmodule

// File: rtl/serDatapath.sv
module serDatapath
  import serRegPkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int NUM_CHAN = 9,
  parameter int NUM_TAP  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic              dataS,
  input  logic [BYTE_W-1:0] statusIn,
  input  logic [BYTE_W/2-1:0] lkChan,
  input  logic [BYTE_W/2-1:0] lkTap,
  output logic [BYTE_W-1:0] lkCoef,
  output logic              serDataOut,
  output logic              serDataOe,
  output logic [1:0]        opMode,
  output logic [1:0]        xferType,
  output logic [BYTE_W/2-1:0] curChan,
  output logic [BYTE_W/2-1:0] curTap
);
  localparam int FIELD_W = BYTE_W / 2;
  localparam int CELLS   = NUM_CHAN * NUM_TAP;
  localparam int IDX_W   = $clog2(CELLS);

  logic [BYTE_W-1:0] shReg;
  logic [BYTE_W-1:0] coefMem [CELLS];
  logic [BYTE_W-1:0] readValue, curCoef;
  logic [IDX_W-1:0]  curIdx, lkIdx;
  logic              addrOk, lkOk;

  assign addrOk = (int'(curChan) < NUM_CHAN) && (int'(curTap) < NUM_TAP);
  assign lkOk   = (int'(lkChan) < NUM_CHAN) && (int'(lkTap) < NUM_TAP);
  assign curIdx = IDX_W'(int'(curChan) * NUM_TAP + int'(curTap));
  assign lkIdx  = IDX_W'(int'(lkChan) * NUM_TAP + int'(lkTap));

  genvar g;
  generate
    for (g = 0; g < CELLS; g++) begin : g_cell
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          coefMem[g] <= '0;
        else if (strobe.commitCoef && addrOk && (curIdx == IDX_W'(g)))
          coefMem[g] <= shReg;
      end
    end
  endgenerate

  always_comb begin
    curCoef = '0;
    lkCoef  = '0;
    for (int i = 0; i < CELLS; i++) begin
      if (addrOk && (curIdx == IDX_W'(i))) curCoef = coefMem[i];
      if (lkOk && (lkIdx == IDX_W'(i)))    lkCoef  = coefMem[i];
    end
  end

  assign readValue = (xferType == XT_READ_STATUS) ? statusIn : curCoef;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      shReg <= '0;
    else if (strobe.loadRead)
      shReg <= readValue;
    else if (strobe.shiftIn)
      shReg <= {dataS, shReg[BYTE_W-1:1]};
    else if (strobe.shiftOut)
      shReg <= {1'b0, shReg[BYTE_W-1:1]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opMode   <= MODE_OFF;
      xferType <= XT_RESET;
      curChan  <= '0;
      curTap   <= '0;
    end else begin
      if (strobe.commitMode) begin
        opMode   <= shReg[1:0];
        xferType <= shReg[3:2];
      end
      if (strobe.commitAddr) begin
        curChan <= shReg[BYTE_W-1:FIELD_W];
        curTap  <= shReg[FIELD_W-1:0];
      end
    end
  end

  assign serDataOut = shReg[0];
  assign serDataOe  = strobe.driveEn;
endmodule

// File: rtl/serRegPort.sv
module serRegPort
  import serRegPkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int NUM_CHAN = 9,
  parameter int NUM_TAP  = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                serEn,
  input  logic [1:0]          serCmd,
  input  logic                serClk,
  input  logic                serDataIn,
  output logic                serDataOut,
  output logic                serDataOe,
  input  logic [BYTE_W-1:0]   statusIn,
  input  logic [BYTE_W/2-1:0] lkChan,
  input  logic [BYTE_W/2-1:0] lkTap,
  output logic [BYTE_W-1:0]   lkCoef,
  output logic [1:0]          opMode,
  output logic [1:0]          xferType,
  output logic [BYTE_W/2-1:0] curChan,
  output logic [BYTE_W/2-1:0] curTap
);
  localparam int SYNC_W = 5;

  logic [SYNC_W-1:0] rawIn, syncOut;
  ctrlStrobe_t       strobe;
  logic              frameOn;
  logic [1:0]        cmdQ;

  assign rawIn = {serEn, serClk, serCmd, serDataIn};

  serSync #(.WIDTH(SYNC_W), .STAGES(2)) sync_i (
    .clk(clk), .rstN(rstN), .din(rawIn), .dout(syncOut)
  );

  serCtrl #(.BYTE_W(BYTE_W)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .enS(syncOut[4]), .clkS(syncOut[3]), .cmdS(syncOut[2:1]),
    .strobe(strobe), .frameOn(frameOn), .cmdQ(cmdQ)
  );

  serDatapath #(.BYTE_W(BYTE_W), .NUM_CHAN(NUM_CHAN), .NUM_TAP(NUM_TAP)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dataS(syncOut[0]),
    .statusIn(statusIn), .lkChan(lkChan), .lkTap(lkTap), .lkCoef(lkCoef),
    .serDataOut(serDataOut), .serDataOe(serDataOe),
    .opMode(opMode), .xferType(xferType), .curChan(curChan), .curTap(curTap)
  );
endmodule

// File: rtl/serRegPortChk.sv
module serRegPortChk
  import serRegPkg::*;
#(
  parameter int BYTE_W = 8
) (
  input logic                clk,
  input logic                rstN,
  input ctrlStrobe_t         strobe,
  input logic                frameOn,
  input logic [1:0]          cmdQ,
  input logic                serDataOe,
  input logic                serDataOut,
  input logic [BYTE_W-1:0]   statusIn,
  input logic [1:0]          opMode,
  input logic [1:0]          xferType,
  input logic [BYTE_W/2-1:0] curChan,
  input logic [BYTE_W/2-1:0] curTap
);
  p_oe_read_frame_r2: assert property (@(posedge clk) disable iff (!rstN)
    serDataOe |-> (frameOn && cmdQ == CMD_READ));

  p_oe_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !frameOn |-> !serDataOe);

  p_one_commit_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.commitMode, strobe.commitAddr, strobe.commitCoef}));

  p_mode_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.commitMode |=> $stable({opMode, xferType}));

  p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.commitAddr |=> $stable({curChan, curTap}));

  p_status_first_bit_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(serDataOe) && xferType == XT_READ_STATUS && $stable(statusIn))
      |-> (serDataOut == statusIn[0]));
endmodule

bind serRegPort serRegPortChk #(.BYTE_W(BYTE_W)) chk_i (
  .clk(clk), .rstN(rstN), .strobe(strobe), .frameOn(frameOn), .cmdQ(cmdQ),
  .serDataOe(serDataOe), .serDataOut(serDataOut), .statusIn(statusIn),
  .opMode(opMode), .xferType(xferType), .curChan(curChan), .curTap(curTap)
);

// File: tb/serRegPort_tb.sv
`timescale 1ns/1ps
module serRegPort_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       serEn = 1'b0;
  logic [1:0] serCmd = 2'b00;
  logic       serClk = 1'b0;
  logic       serDataIn = 1'b0;
  logic       serDataOut, serDataOe;
  logic [7:0] statusIn = 8'h00;
  logic [3:0] lkChan = 4'd0, lkTap = 4'd0;
  logic [7:0] lkCoef;
  logic [1:0] opMode, xferType;
  logic [3:0] curChan, curTap;

  int checks = 0;
  int fails = 0;
  bit settled = 1'b0;
  bit finished = 1'b0;

  int mMode, mType, mChan, mTap;
  int mCoef [108];

  always #2.5 clk = ~clk;

  serRegPort dut_i (
    .clk(clk), .rstN(rstN), .serEn(serEn), .serCmd(serCmd), .serClk(serClk),
    .serDataIn(serDataIn), .serDataOut(serDataOut), .serDataOe(serDataOe),
    .statusIn(statusIn), .lkChan(lkChan), .lkTap(lkTap), .lkCoef(lkCoef),
    .opMode(opMode), .xferType(xferType), .curChan(curChan), .curTap(curTap)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int mValid(input int c, input int t);
    return (c < 9 && t < 12) ? 1 : 0;
  endfunction

  function automatic int mCell(input int c, input int t);
    return mValid(c, t) ? mCoef[c*12+t] : 0;
  endfunction

  // per-clock comparison against the model while no frame is in flight
  always @(negedge clk) begin
    if (settled && rstN && !finished) begin
      chk(opMode == mMode[1:0], "R4 opMode", opMode, mMode);
      chk(xferType == mType[1:0], "R4 xferType", xferType, mType);
      chk(curChan == mChan[3:0], "R5 curChan", curChan, mChan);
      chk(curTap == mTap[3:0], "R5 curTap", curTap, mTap);
      chk(lkCoef == 8'(mCell(lkChan, lkTap)), "R6 lkCoef", lkCoef, mCell(lkChan, lkTap));
      chk(serDataOe == 1'b0, "R2 oe idle", serDataOe, 0);
    end
  end

  task automatic doFrame(input logic [1:0] cmd, input logic [7:0] data, input int nbits,
                         input bit swapCmd, output logic [7:0] got);
    logic [7:0] expRd;
    int oldCell, newCell;
    bit watch, seenNew;
    string rdReq;
    expRd = (mType == 3) ? statusIn : 8'(mCell(mChan, mTap));
    rdReq = (mType == 3) ? "R8 status read" : "R9 coef read";
    watch = (cmd == 2'b00) && (nbits >= 8) && (lkChan == 4'(mChan)) && (lkTap == 4'(mTap))
            && (mValid(mChan, mTap) != 0);
    oldCell = mCell(mChan, mTap);
    newCell = data;
    seenNew = 1'b0;
    got = 8'h00;
    @(negedge clk);
    settled = 1'b0;
    serCmd = cmd;
    repeat (4) @(negedge clk);
    serEn = 1'b1;
    repeat (8) @(negedge clk);
    if (swapCmd) serCmd = ~cmd;
    for (int i = 0; i < nbits; i++) begin
      serDataIn = (i < 8) ? data[i] : ~data[i%8];
      repeat (8) @(negedge clk);
      chk(serDataOe == (cmd == 2'b01), "R2 oe in frame", serDataOe, int'(cmd == 2'b01));
      if (i < 8) got[i] = serDataOut;
      if (cmd == 2'b01 && i < 8)
        chk(serDataOut == expRd[i], rdReq, serDataOut, expRd[i]);
      serClk = 1'b1;
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        if (watch && i == 7) begin
          if (lkCoef == 8'(newCell)) seenNew = 1'b1;
          chk((lkCoef == 8'(oldCell) && !seenNew) || lkCoef == 8'(newCell),
              "R6 same-cycle lookup", lkCoef, seenNew ? newCell : oldCell);
        end
      end
      serClk = 1'b0;
    end
    repeat (8) @(negedge clk);
    serEn = 1'b0;
    serCmd = 2'b00;
    if (nbits >= 8) begin
      case (cmd)
        2'b11: begin mMode = data[1:0]; mType = data[3:2]; end
        2'b10: begin mChan = data[7:4]; mTap = data[3:0]; end
        2'b00: if (mValid(mChan, mTap) != 0) mCoef[mChan*12+mTap] = data;
        default: ;
      endcase
    end
    repeat (8) @(negedge clk);
    if (watch) chk(seenNew, "R6 commit seen", seenNew, 1);
    settled = 1'b1;
  endtask

  task automatic sweepCells(input string req);
    settled = 1'b0;
    for (int c = 0; c < 16; c++)
      for (int t = 0; t < 16; t++) begin
        lkChan = 4'(c); lkTap = 4'(t);
        @(negedge clk);
        chk(lkCoef == 8'(mCell(c, t)), req, lkCoef, mCell(c, t));
      end
    settled = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] got;
    mMode = 3; mType = 1; mChan = 0; mTap = 0;
    foreach (mCoef[i]) mCoef[i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(opMode == 2'b11, "R1 mode off", opMode, 3);
    chk(xferType == 2'b01, "R1 type", xferType, 1);
    chk(curChan == 0 && curTap == 0, "R1 addr", {curChan, curTap}, 0);
    chk(serDataOe == 1'b0, "R1 oe", serDataOe, 0);
    sweepCells("R1 coef zero");

    // R4: upper nibble ignored
    doFrame(2'b11, 8'hF6, 8, 1'b0, got);
    chk(opMode == 2'b10 && xferType == 2'b01, "R4 mode F6", {opMode, xferType}, 4'b1001);

    // R5 then R6 with lookup on the written cell
    doFrame(2'b10, 8'h35, 8, 1'b0, got);
    lkChan = 4'd3; lkTap = 4'd5;
    doFrame(2'b00, 8'hA7, 8, 1'b0, got);
    doFrame(2'b01, 8'h00, 8, 1'b0, got);
    chk(got == 8'hA7, "R9 readback", got, 8'hA7);

    // auxiliary channel, last tap
    doFrame(2'b10, 8'h8B, 8, 1'b0, got);
    lkChan = 4'd8; lkTap = 4'd11;
    doFrame(2'b00, 8'h5C, 8, 1'b0, got);
    doFrame(2'b01, 8'h00, 8, 1'b0, got);
    chk(got == 8'h5C, "R9 aux tap 11", got, 8'h5C);

    // R7 invalid addresses
    doFrame(2'b10, 8'h90, 8, 1'b0, got);
    doFrame(2'b00, 8'hFF, 8, 1'b0, got);
    doFrame(2'b01, 8'h00, 8, 1'b0, got);
    chk(got == 8'h00, "R7 read invalid chan", got, 0);
    doFrame(2'b10, 8'h0C, 8, 1'b0, got);
    doFrame(2'b00, 8'hEE, 8, 1'b0, got);
    sweepCells("R7 no cell changed");

    // R8 status read
    statusIn = {1'b1, 5'b10110, 2'b01};
    doFrame(2'b11, 8'h0C, 8, 1'b0, got);
    doFrame(2'b01, 8'h00, 8, 1'b0, got);
    chk(got == statusIn, "R8 status byte", got, statusIn);

    // R3 short frame commits nothing, long frame keeps first 8 bits
    doFrame(2'b10, 8'h22, 5, 1'b0, got);
    chk(curChan == 4'd0 && curTap == 4'd12, "R3 short frame", {curChan, curTap}, 8'h0C);
    doFrame(2'b10, 8'h47, 11, 1'b0, got);
    chk(curChan == 4'd4 && curTap == 4'd7, "R3 long frame", {curChan, curTap}, 8'h47);

    // R10 command change mid frame
    doFrame(2'b10, 8'h16, 8, 1'b1, got);
    chk(curChan == 4'd1 && curTap == 4'd6, "R10 latched cmd", {curChan, curTap}, 8'h16);
    doFrame(2'b11, 8'h04, 8, 1'b0, got);
    lkChan = 4'd1; lkTap = 4'd6;
    doFrame(2'b00, 8'h81, 8, 1'b1, got);
    doFrame(2'b01, 8'h00, 8, 1'b0, got);
    chk(got == 8'h81, "R10 coef via swapped cmd", got, 8'h81);
    sweepCells("R6 final array");

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule